// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital heart of an 8-bit successive-approximation analog-to-digital converter. A host bus presents three active-low strobes (select, start and read) that arrive asynchronously to the converter clock. An external DAC and comparator close the analog loop: the block drives a trial code, and the comparator returns one bit saying whether the sampled input is at or above that code.

A conversion is armed by pulling start and select low together. The block stays in its reset state while both are low, and it begins work on the next phase boundary of a free-running eight-phase counter once either strobe is released. Each result bit takes one eight-clock phase period, beginning with the most significant bit. The finished code is copied into an output latch, and an active-low completion flag then falls. A read with select low clears the flag and drives the latch onto a tri-state bus.

Tying select and read low and feeding the flag back into start gives continuous conversion. Restarting in the middle of a conversion abandons it, and the previous result stays in the latch.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After synchronous reset, doneN is high, trialCode is 0x00 and the result latch holds 0x00.
- R2: While synchronised select and start are both low, the block holds its reset state: doneN is high, trialCode is 0x00 and no bit is resolved.
- R3: Approximation begins on the first phase 0 of a free-running eight-phase counter after either select or start is released. With the default two synchroniser stages, doneN falls between 67 and 74 clock edges after the startN rise.
- R4: Bits are tested from MSB to LSB. trialCode equals the bits decided so far with the bit under test set and the lower bits clear, so the first trial is 0x80. cmpHi is sampled on phase 7 of each bit period, and a 1 keeps the bit.
- R5: With cmpHi = 1 exactly when the input code is greater than or equal to trialCode, the latched result equals the input code. The latch changes only in the cycle that resolves bit 0.
- R6: doneN falls only when a conversion completes.
- R7: readN and selN both low clear doneN within three clock edges. readN low with selN high leaves doneN unchanged.
- R8: A restart during a conversion abandons it and leaves the result latch at the last completed value.
- R9: dataBus carries the latch only while readN and selN are both low, combinationally from those pins. Otherwise it is high-impedance.
- R10: With selN and readN tied low and doneN fed back to startN, conversions repeat without further stimulus, each producing the input code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| selN | input | 1 | Chip select, active low, asynchronous |
| startN | input | 1 | Start strobe, active low, asynchronous |
| readN | input | 1 | Output enable / flag clear, active low, asynchronous |
| cmpHi | input | 1 | Comparator decision: 1 when input is at or above trialCode |
| trialCode | output | 8 | Code driven to the external DAC |
| doneN | output | 1 | Completion flag, active low |
| dataBus | output | 8 | Tri-state result bus |

## Verification
The bench sweeps how long start is held low, so that the release lands on every phase of the eight-phase counter. A design that restarted the counter, or that started conversion without waiting for phase alignment, would finish outside the 67 to 74 clock window. An aborted conversion is read back during the restart hold, where a design that latched partial results would show a stale or mixed code instead of the previous value. The bench also reads with select high while placing its own pattern on the bus: a design that ignored select would either clear the flag or cause bus contention. A free-running loop checks that the flag pulse is long enough to survive the synchronisers and relaunch conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_WAIT, ST_CONV} ctlState_e;

  typedef struct packed {
    logic clearSar;
    logic decide;
    logic commit;
    logic converting;
  } sarStrobe_t;
endpackage

// File: rtl/sar_strobe_sync.sv
module sar_strobe_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] asyncIn,
  output logic [N-1:0] syncOut
);
  logic [STAGES-1:0][N-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PHASES = 8,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int PH_W  = $clog2(PHASES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             selS,
  input  logic             startS,
  input  logic             readS,
  output sarStrobe_t       strb,
  output logic [IDX_W-1:0] bitIdx,
  output logic             doneN
);
  ctlState_e       state;
  logic [PH_W-1:0] phase;
  logic            lastPhase, holdReq, readReq, decideNow;

  assign lastPhase = (phase == PH_W'(PHASES - 1));
  assign holdReq   = !selS && !startS;
  assign readReq   = !readS && !selS;
  assign decideNow = (state == ST_CONV) && lastPhase && !holdReq;

  always_comb begin
    strb.clearSar   = holdReq;
    strb.decide     = decideNow;
    strb.commit     = decideNow && (bitIdx == '0);
    strb.converting = (state == ST_CONV);
  end

  // free-running phase counter: conversion aligns to its wrap
  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= lastPhase ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitIdx <= IDX_W'(DATA_W - 1);
      doneN  <= 1'b1;
    end else if (holdReq) begin
      state  <= ST_HOLD;
      bitIdx <= IDX_W'(DATA_W - 1);
      doneN  <= 1'b1;
    end else begin
      if (readReq) doneN <= 1'b1;
      case (state)
        ST_HOLD: state <= lastPhase ? ST_CONV : ST_WAIT;
        ST_WAIT: if (lastPhase) state <= ST_CONV;
        ST_CONV: if (lastPhase) begin
          if (bitIdx == '0) begin
            state <= ST_IDLE;
            doneN <= 1'b0;
          end else begin
            bitIdx <= bitIdx - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r2_hold_resets: assert property (@(posedge clk) disable iff (rst)
    holdReq |=> (state == ST_HOLD) && doneN);

  a_r3_conv_on_phase0: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_CONV) && ($past(state) != ST_CONV)) |-> (phase == '0));

  a_r6_flag_falls_on_finish: assert property (@(posedge clk) disable iff (rst)
    $fell(doneN) |-> $past(strb.commit));

  a_r7_read_clears_flag: assert property (@(posedge clk) disable iff (rst)
    (readReq && !strb.commit) |=> doneN);
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  sarStrobe_t        strb,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              cmpHi,
  output logic [DATA_W-1:0] trialCode,
  output logic [DATA_W-1:0] resultLatch
);
  logic [DATA_W-1:0] sarReg, testMask;

  assign testMask  = strb.converting ? (DATA_W'(1) << bitIdx) : '0;
  assign trialCode = sarReg | testMask;

  always_ff @(posedge clk) begin
    if (rst || strb.clearSar) sarReg <= '0;
    else if (strb.decide)     sarReg[bitIdx] <= cmpHi;
  end

  always_ff @(posedge clk) begin
    if (rst)              resultLatch <= '0;
    else if (strb.commit) resultLatch <= sarReg | DATA_W'(cmpHi);
  end

  a_r2_clear_empties_sar: assert property (@(posedge clk) disable iff (rst)
    strb.clearSar |=> (sarReg == '0));

  a_r4_bit_follows_cmp: assert property (@(posedge clk) disable iff (rst)
    strb.decide |=> (sarReg[$past(bitIdx)] == $past(cmpHi)));

  // R5 and R8: latch only moves on a completed conversion
  a_r8_latch_holds: assert property (@(posedge clk) disable iff (rst)
    !strb.commit |=> $stable(resultLatch));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PHASES      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selN,
  input  logic              startN,
  input  logic              readN,
  input  logic              cmpHi,
  output logic [DATA_W-1:0] trialCode,
  output logic              doneN,
  output wire  [DATA_W-1:0] dataBus
);
  localparam int IDX_W = $clog2(DATA_W);

  logic              selS, startS, readS, busEn;
  sarStrobe_t        strb;
  logic [IDX_W-1:0]  bitIdx;
  logic [DATA_W-1:0] resultLatch;

  sar_strobe_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .asyncIn({selN, startN, readN}),
    .syncOut({selS, startS, readS})
  );

  sar_ctrl #(.DATA_W(DATA_W), .PHASES(PHASES)) u_ctrl (
    .clk(clk), .rst(rst), .selS(selS), .startS(startS), .readS(readS),
    .strb(strb), .bitIdx(bitIdx), .doneN(doneN)
  );

  sar_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .bitIdx(bitIdx), .cmpHi(cmpHi),
    .trialCode(trialCode), .resultLatch(resultLatch)
  );

  assign busEn   = !readN && !selN;
  assign dataBus = busEn ? resultLatch : 'z;
endmodule

// File: tb/sar_conv_ctrl_bench.sv
`timescale 1ns/1ps
module sar_conv_ctrl_bench;
  logic clk = 1'b0;
  logic rst, selN, startDrv, readN, freeRun, kickN, tbDrive, monOn, startN, cmpHi;
  logic [7:0] vin, trialCode;
  logic doneN;
  wire  [7:0] dataBus;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] expQ[$];

  always #10 clk = ~clk;

  always_comb startN = freeRun ? (doneN & kickN) : startDrv;
  assign cmpHi   = (vin >= trialCode);
  assign dataBus = tbDrive ? 8'hC3 : 'z;

  sar_conv_ctrl u_sar_conv_ctrl (
    .clk(clk), .rst(rst), .selN(selN), .startN(startN), .readN(readN),
    .cmpHi(cmpHi), .trialCode(trialCode), .doneN(doneN), .dataBus(dataBus)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // driver: pushes the expected code, pulses start, measures latency (R3)
  task automatic startConv(input logic [7:0] v, input int holdCyc, input bit push);
    int cnt;
    bit bad;
    vin = v;
    if (push) expQ.push_back(v);
    @(negedge clk);
    startDrv = 1'b0;
    bad = 0;
    for (int i = 0; i < holdCyc; i++) begin
      @(negedge clk);
      if (i >= 3 && (doneN !== 1'b1 || trialCode !== 8'h00)) bad = 1;
    end
    if (holdCyc >= 8) check(!bad, "R2", "hold keeps reset state", bad, 0);
    startDrv = 1'b1;
    cnt = 0;
    while (doneN === 1'b1 && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt >= 67 && cnt <= 74, "R3", "start-to-done clocks", cnt, 74);
    repeat (10) @(negedge clk);
  endtask

  // monitor: on each completion read the bus and compare with the queue
  initial begin
    forever begin
      @(negedge doneN);
      if (monOn) begin
        @(negedge clk);
        readN = 1'b0;
        #1;
        if (expQ.size() == 0) begin
          check(0, "R6", "unexpected completion", dataBus, 0);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(dataBus === e, "R5", "converted code", dataBus, e);
        end
        repeat (5) @(negedge clk);
        check(doneN === 1'b1, "R7", "read clears flag", doneN, 1);
        readN = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    logic [7:0] prev;
    int falls;
    bit prevDone, busOk;
    rst = 1'b1; selN = 1'b1; startDrv = 1'b1; readN = 1'b1;
    freeRun = 1'b0; kickN = 1'b1; tbDrive = 1'b0; monOn = 1'b1; vin = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(doneN === 1'b1, "R1", "reset doneN", doneN, 1);
    check(trialCode === 8'h00, "R1", "reset trialCode", trialCode, 0);
    selN = 1'b0;
    readN = 1'b0;
    #1;
    check(dataBus === 8'h00, "R1", "reset latch", dataBus, 0);
    readN = 1'b1;

    // R4/R5: sweep codes and hold lengths to hit every phase alignment
    startConv(8'h00, 3, 1);
    startConv(8'hFF, 4, 1);
    startConv(8'hA5, 5, 1);
    startConv(8'h5A, 6, 1);
    startConv(8'h80, 7, 1);
    startConv(8'h01, 8, 1);
    startConv(8'h7F, 9, 1);
    startConv(8'h3C, 20, 1);   // long hold, R2
    prev = 8'h3C;

    // R8 abort, with R4 trial order
    vin = 8'hCC;
    @(negedge clk); startDrv = 1'b0;
    repeat (3) @(negedge clk); startDrv = 1'b1;
    for (int i = 0; i < 14 && trialCode === 8'h00; i++) @(negedge clk);
    check(trialCode === 8'h80, "R4", "first trial MSB", trialCode, 8'h80);
    repeat (8) @(negedge clk);
    check(trialCode === 8'hC0, "R4", "second trial", trialCode, 8'hC0);
    repeat (10) @(negedge clk);
    check(doneN === 1'b1, "R6", "no flag mid-conversion", doneN, 1);
    startDrv = 1'b0;
    repeat (5) @(negedge clk);
    readN = 1'b0;
    #1;
    check(dataBus === prev, "R8", "latch kept after abort", dataBus, prev);
    check(trialCode === 8'h00, "R2", "abort clears trial", trialCode, 0);
    readN = 1'b1;
    startConv(8'h77, 3, 1);

    // R7/R9 without the monitor
    monOn = 1'b0;
    startConv(8'h4E, 3, 0);
    selN = 1'b1;
    readN = 1'b0;
    tbDrive = 1'b1;
    repeat (6) @(negedge clk);
    check(doneN === 1'b0, "R7", "read without select keeps flag", doneN, 0);
    check(dataBus === 8'hC3, "R9", "bus released with select high", dataBus, 8'hC3);
    selN = 1'b0;
    readN = 1'b1;
    #1;
    check(dataBus === 8'hC3, "R9", "bus released with read high", dataBus, 8'hC3);
    tbDrive = 1'b0;
    readN = 1'b0;
    #1;
    check(dataBus === 8'h4E, "R9", "bus driven on read", dataBus, 8'h4E);
    repeat (4) @(negedge clk);
    check(doneN === 1'b1, "R7", "read with select clears flag", doneN, 1);
    readN = 1'b1;
    repeat (4) @(negedge clk);

    // R10 free-running loop
    vin = 8'h96;
    readN = 1'b0;
    freeRun = 1'b1;
    kickN = 1'b0;
    repeat (3) @(negedge clk);
    kickN = 1'b1;
    falls = 0;
    prevDone = 1'b1;
    busOk = 1'b1;
    for (int i = 0; i < 420; i++) begin
      @(negedge clk);
      if (!doneN && prevDone) begin
        falls++;
        if (dataBus !== 8'h96) busOk = 1'b0;
      end
      prevDone = doneN;
    end
    check(falls >= 4, "R10", "free-running completions", falls, 4);
    check(busOk, "R10", "free-running code", busOk, 1);
    freeRun = 1'b0;
    readN = 1'b1;
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule